// File: doc/BRIEF.md
# Serial-Loaded Mapper Register Port

This block is the processor-facing write side of a cartridge bank-switching controller. The processor has no parallel path into the controller's configuration. Each store to the upper half of the address space carries one bit on data line 0. After five such stores, the gathered value lands in one of four configuration registers. Address lines 14:13 of the fifth store pick the register. A store with data bit 7 set abandons any partial sequence. It also forces the two mode bits of the control register high.

Some processors issue more than one store in close succession for a single instruction. To cope with this, the port accepts a store and then discards every store that arrives during the next few clocks. The register values leave the block as plain outputs. A one-clock commit strobe and the index of the register just written let downstream bank-translation logic react. A RAM-enable output follows an active-low bit of the fourth register. Parameters select whether that bit has any effect and whether the RAM starts out disabled.

Top module: `serial_bank_port`

## Requirements
- R1: A store whose address bit 15 is 0 is ignored. It advances no shift position, changes no register, starts no cooldown and raises no strobe.
- R2: An accepted store with data bit 7 set clears the shift position and the gathered bits. It sets bits 3:2 of the control register (register 0) to 1 and leaves its other bits unchanged. It raises no strobe.
- R3: Bits arrive least significant first. The first accepted store of a sequence supplies bit 0 of the result, and the fifth store supplies bit 4.
- R4: The fifth accepted store writes the 5-bit result into the register chosen by address bits 14:13: 0 is control, 1 is bank A, 2 is bank B, 3 is bank P. The next sequence then starts from an empty shift position.
- R5: After an accepted store, every store in the following 3 clocks is discarded, including stores with bit 7 set. Store attempts made on every clock are therefore accepted only on every fourth clock.
- R6: After reset, control reads 0x0C and banks A, B and P read 0.
- R7: With RAM_EN_CTL=1, a commit to bank P sets ram_en to the inverse of bit 4 of the committed value. No other event changes ram_en.
- R8: After reset, ram_en is 0 when RAM_START_OFF=1 and 1 when it is 0. With the defaults, ram_en is 0.
- R9: commit_stb is high for exactly the one clock in which the new register value first appears at the outputs. In that clock, commit_idx carries the register index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; cooldown counts these edges |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store strobe, sampled on each rising edge |
| wr_addr | input | 16 | Store address |
| wr_data | input | 8 | Store data; bit 0 is the serial bit, bit 7 is abort |
| ctrl_q | output | 5 | Register 0 (control) |
| bank_a_q | output | 5 | Register 1 |
| bank_b_q | output | 5 | Register 2 |
| bank_p_q | output | 5 | Register 3 |
| ram_en | output | 1 | Work-RAM enable, active high |
| commit_stb | output | 1 | One-clock pulse on a register commit |
| commit_idx | output | 2 | Index of the register just committed |

## Verification
On every clock, the embedded assertions check the local rules of the port. An accepted store is never followed by another accepted store on the next clock. An abort or commit always leaves the shift state empty. An abort forces the control mode bits high. Registers and the RAM enable stay unchanged unless a commit or abort occurred. A store below the window never produces a strobe.

Some behaviours only the bench's scenarios can show. The bits must assemble in the right order, and the right register must receive them. A partial sequence must survive discarded and out-of-window stores. When stores arrive on every clock, only every fourth one may count. These depend on multi-store histories, so the bench compares against a behavioural model on every clock and adds directed value checks.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   // Register indices as selected by address bits 14:13
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_BANK_A = 2'd1,
      SEL_BANK_B = 2'd2,
      SEL_BANK_P = 2'd3
   } reg_sel_e;

   localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/sbp_gate.sv
module sbp_gate #(
   parameter int unsigned COOLDOWN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic in_window,
   output logic accept_o
);
   localparam int unsigned CW = $clog2(COOLDOWN + 1);

   if (COOLDOWN < 1) begin : g_bad_cool
      $error("sbp_gate: COOLDOWN must be at least 1");
   end

   logic [CW-1:0] cool_q;

   assign accept_o = wr_en & in_window & (cool_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cool_q <= '0;
      else if (accept_o)
         cool_q <= CW'(COOLDOWN);
      else if (cool_q != '0)
         cool_q <= cool_q - 1'b1;
   end

   // R5
   back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> !accept_o);
   // R5
   cool_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cool_q <= CW'(COOLDOWN));
endmodule

// File: rtl/sbp_shifter.sv
module sbp_shifter #(
   parameter int unsigned REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             bit_in,
   input  logic             abort_in,
   output logic             abort_v,
   output logic             commit_v,
   output logic [REG_W-1:0] commit_val
);
   localparam int unsigned CNT_W = $clog2(REG_W + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [REG_W-1:0] buf_q;
   logic [REG_W-1:0] buf_nx;

   assign abort_v  = accept & abort_in;
   assign commit_v = accept & ~abort_in & (cnt_q == CNT_W'(REG_W - 1));

   always_comb begin
      buf_nx = buf_q;
      for (int i = 0; i < REG_W; i++)
         if (cnt_q == CNT_W'(i)) buf_nx[i] = bit_in;
   end

   assign commit_val = buf_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         buf_q <= '0;
      end else if (abort_v || commit_v) begin
         cnt_q <= '0;
         buf_q <= '0;
      end else if (accept) begin
         cnt_q <= cnt_q + 1'b1;
         buf_q <= buf_nx;
      end
   end

   // R4
   commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_v |=> (cnt_q == '0 && buf_q == '0));
   // R2
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_v |=> (cnt_q == '0 && buf_q == '0));
   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(REG_W));
endmodule

// File: rtl/sbp_regfile.sv
module sbp_regfile
   import sbp_pkg::*;
#(
   parameter int unsigned REG_W         = 5,
   parameter int unsigned CTRL_RST      = 12,
   parameter int unsigned MODE_SET      = 12,
   parameter bit          RAM_EN_CTL    = 1'b1,
   parameter bit          RAM_START_OFF = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           commit_v,
   input  logic [1:0]                     commit_sel,
   input  logic [REG_W-1:0]               commit_val,
   input  logic                           abort_v,
   output logic [NUM_REGS-1:0][REG_W-1:0] regs_o,
   output logic                           ram_en_o,
   output logic                           stb_o,
   output logic [1:0]                     idx_o
);
   localparam int unsigned RAM_BIT = REG_W - 1;
   localparam logic [REG_W-1:0] MODE_MASK = REG_W'(MODE_SET);

   logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [REG_W-1:0] RST_V = (g == 0) ? REG_W'(CTRL_RST) : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs_q[g] <= RST_V;
         else if (commit_v && commit_sel == 2'(g))
            regs_q[g] <= commit_val;
         else if (g == 0 && abort_v)
            regs_q[g] <= regs_q[g] | MODE_MASK;
      end
   end

   if (RAM_EN_CTL) begin : g_ram_ctl
      logic ram_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ram_q <= ~RAM_START_OFF;
         else if (commit_v && commit_sel == SEL_BANK_P)
            ram_q <= ~commit_val[RAM_BIT];
      end
      assign ram_en_o = ram_q;
      // R7
      ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(commit_v && commit_sel == SEL_BANK_P) |=> $stable(ram_q));
   end else begin : g_ram_fixed
      assign ram_en_o = ~RAM_START_OFF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_o <= 1'b0;
         idx_o <= '0;
      end else begin
         stb_o <= commit_v;
         if (commit_v) idx_o <= commit_sel;
      end
   end

   assign regs_o = regs_q;

   // R9
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o);
   // R2
   abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_v |=> ((regs_q[0] & MODE_MASK) == MODE_MASK));
   // R4
   regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_v && !abort_v |=> $stable(regs_q));
   // R2
   abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(abort_v && commit_v));
endmodule

// File: rtl/serial_bank_port.sv
module serial_bank_port
   import sbp_pkg::*;
#(
   parameter int unsigned ADDR_W        = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned REG_W         = 5,
   parameter int unsigned COOLDOWN      = 3,
   parameter bit          RAM_EN_CTL    = 1'b1,
   parameter bit          RAM_START_OFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [REG_W-1:0]  ctrl_q,
   output logic [REG_W-1:0]  bank_a_q,
   output logic [REG_W-1:0]  bank_b_q,
   output logic [REG_W-1:0]  bank_p_q,
   output logic              ram_en,
   output logic              commit_stb,
   output logic [1:0]        commit_idx
);
   localparam int unsigned WIN_BIT   = ADDR_W - 1;
   localparam int unsigned SEL_HI    = ADDR_W - 2;
   localparam int unsigned ABORT_BIT = DATA_W - 1;

   if (ADDR_W < 4)  begin : g_bad_addr  $error("serial_bank_port: ADDR_W too small");  end
   if (DATA_W < 2)  begin : g_bad_data  $error("serial_bank_port: DATA_W too small");  end
   if (REG_W < 5)   begin : g_bad_reg   $error("serial_bank_port: REG_W below 5");      end

   logic                           accept;
   logic                           abort_v;
   logic                           commit_v;
   logic [REG_W-1:0]               commit_val;
   logic [1:0]                     sel;
   logic [NUM_REGS-1:0][REG_W-1:0] regs;

   assign sel = wr_addr[SEL_HI -: 2];

   sbp_gate #(.COOLDOWN(COOLDOWN)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .in_window (wr_addr[WIN_BIT]),
      .accept_o  (accept)
   );

   sbp_shifter #(.REG_W(REG_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .bit_in     (wr_data[0]),
      .abort_in   (wr_data[ABORT_BIT]),
      .abort_v    (abort_v),
      .commit_v   (commit_v),
      .commit_val (commit_val)
   );

   sbp_regfile #(
      .REG_W         (REG_W),
      .RAM_EN_CTL    (RAM_EN_CTL),
      .RAM_START_OFF (RAM_START_OFF)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_v   (commit_v),
      .commit_sel (sel),
      .commit_val (commit_val),
      .abort_v    (abort_v),
      .regs_o     (regs),
      .ram_en_o   (ram_en),
      .stb_o      (commit_stb),
      .idx_o      (commit_idx)
   );

   assign ctrl_q   = regs[SEL_CTRL];
   assign bank_a_q = regs[SEL_BANK_A];
   assign bank_b_q = regs[SEL_BANK_B];
   assign bank_p_q = regs[SEL_BANK_P];

   // R1
   outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr[WIN_BIT]) |-> !accept);
   // R9
   stb_follows_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_v |=> (commit_stb && commit_idx == $past(sel)));
endmodule

// File: tb/serial_bank_port_test.sv
module serial_bank_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [4:0]  ctrl_q, bank_a_q, bank_b_q, bank_p_q;
   logic        ram_en, commit_stb;
   logic [1:0]  commit_idx;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   serial_bank_port uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl_q(ctrl_q), .bank_a_q(bank_a_q), .bank_b_q(bank_b_q), .bank_p_q(bank_p_q),
      .ram_en(ram_en), .commit_stb(commit_stb), .commit_idx(commit_idx)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_cnt, m_buf, m_cool, m_ram, m_stb, m_idx;
   int m_reg [4];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_buf = 0; m_cool = 0; m_ram = 0; m_stb = 0; m_idx = 0;
         m_reg[0] = 12; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      end else begin
         bit take;
         take = wr_en && wr_addr[15] && (m_cool == 0);
         m_stb = 0;
         if (m_cool > 0) m_cool--;
         if (take) begin
            m_cool = 3;
            if (wr_data[7]) begin
               m_reg[0] = m_reg[0] | 12; m_cnt = 0; m_buf = 0;
            end else begin
               m_buf = m_buf | (int'(wr_data[0]) << m_cnt);
               m_cnt++;
               if (m_cnt == 5) begin
                  m_idx = int'(wr_addr[14:13]);
                  m_reg[m_idx] = m_buf;
                  if (m_idx == 3) m_ram = ((m_buf >> 4) & 1) == 0 ? 1 : 0;
                  m_stb = 1; m_cnt = 0; m_buf = 0;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(ctrl_q == 5'(m_reg[0]),   "R4 model ctrl",   ctrl_q,   m_reg[0]);
         chk(bank_a_q == 5'(m_reg[1]), "R4 model bank_a", bank_a_q, m_reg[1]);
         chk(bank_b_q == 5'(m_reg[2]), "R4 model bank_b", bank_b_q, m_reg[2]);
         chk(bank_p_q == 5'(m_reg[3]), "R4 model bank_p", bank_p_q, m_reg[3]);
         chk(ram_en == 1'(m_ram),      "R7 model ram_en", ram_en,   m_ram);
         chk(commit_stb == 1'(m_stb),  "R9 model strobe", commit_stb, m_stb);
         if (m_stb != 0)
            chk(commit_idx == 2'(m_idx), "R9 model index", commit_idx, m_idx);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // one store then three idle clocks; starts and ends at a falling edge
   task automatic store(input logic [15:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic load(input logic [15:0] a, input logic [4:0] v, input string tag);
      for (int i = 0; i < 4; i++) store(a, {7'd0, v[i]});
      wr_en = 1'b1; wr_addr = a; wr_data = {7'd0, v[4]};
      @(negedge clk);
      wr_en = 1'b0;
      chk(commit_stb == 1'b1, {tag, " R9 strobe"}, commit_stb, 1);
      chk(commit_idx == a[14:13], {tag, " R9 index"}, commit_idx, a[14:13]);
      @(negedge clk);
      chk(commit_stb == 1'b0, {tag, " R9 strobe width"}, commit_stb, 0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 / R8 reset state
      chk(ctrl_q == 5'h0C, "R6 ctrl reset", ctrl_q, 5'h0C);
      chk(bank_a_q == 0 && bank_b_q == 0 && bank_p_q == 0, "R6 banks reset",
          {bank_a_q, bank_b_q, bank_p_q}, 0);
      chk(ram_en == 1'b0, "R8 ram starts off", ram_en, 0);
      chk(commit_stb == 1'b0, "R9 no strobe at reset", commit_stb, 0);

      // R3 / R4: LSB first into bank A
      load(16'hA000, 5'h15, "bankA");
      chk(bank_a_q == 5'h15, "R3 R4 bank_a value", bank_a_q, 5'h15);
      load(16'hB3FF, 5'h06, "bankA2");
      chk(bank_a_q == 5'h06, "R3 bank_a order", bank_a_q, 5'h06);

      // R2: abort forces mode bits
      load(16'h8000, 5'h03, "ctrl");
      chk(ctrl_q == 5'h03, "R4 ctrl value", ctrl_q, 5'h03);
      wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h80;
      @(negedge clk);
      wr_en = 1'b0;
      chk(commit_stb == 1'b0, "R2 abort no strobe", commit_stb, 0);
      chk(ctrl_q == 5'h0F, "R2 abort sets mode bits", ctrl_q, 5'h0F);
      repeat (3) @(negedge clk);

      // R2: partial sequence discarded by abort
      for (int i = 0; i < 3; i++) store(16'hC000, 8'h01);
      store(16'hC000, 8'hFF);
      load(16'hC000, 5'h0A, "bankB");
      chk(bank_b_q == 5'h0A, "R2 fresh sequence after abort", bank_b_q, 5'h0A);

      // R1: stores below the window do not advance the sequence
      store(16'h6000, 8'h01);
      store(16'h7FFF, 8'h81);
      chk(ctrl_q == 5'h0F, "R1 low abort ignored", ctrl_q, 5'h0F);
      load(16'hE000, 5'h10, "bankP");
      chk(bank_p_q == 5'h10, "R1 R4 bank_p value", bank_p_q, 5'h10);
      chk(ram_en == 1'b0, "R7 ram disabled by bit4", ram_en, 0);
      load(16'hE000, 5'h05, "bankP2");
      chk(ram_en == 1'b1, "R7 ram enabled", ram_en, 1);
      load(16'hA000, 5'h10, "bankA3");
      chk(ram_en == 1'b1, "R7 other reg leaves ram", ram_en, 1);

      // R5: stores on every clock, only every fourth counts
      for (int i = 0; i < 17; i++) begin
         wr_en = 1'b1; wr_addr = 16'hA000; wr_data = (i % 4 == 0) ? 8'h01 : 8'h00;
         @(negedge clk);
      end
      wr_en = 1'b0;
      repeat (4) @(negedge clk);
      chk(bank_a_q == 5'h1F, "R5 every fourth accepted", bank_a_q, 5'h1F);

      // R5: abort during cooldown is discarded
      wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h01;
      @(negedge clk);
      wr_data = 8'h80;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 4; i++) store(16'h8000, 8'h00);
      chk(ctrl_q == 5'h01, "R5 abort in cooldown ignored", ctrl_q, 5'h01);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule